// File: doc/BRIEF.md
# UART Prioritized Interrupt Identification

This block is the interrupt arbiter of one UART channel that may run with or without receive and transmit FIFOs. Five status conditions arrive from the rest of the channel: a line-error event, a receive-data-ready (or trigger-level-reached) level, a character-timeout event, a transmit-holding-empty level and a modem-change event. The block keeps a pending flag for each condition, masks the flags with a four-bit enable register, and drives one registered interrupt request line.

A read of the identification register returns a byte that names the most urgent enabled pending condition. The block also carries out the side effects that clear sources when registers are accessed. Reads of the line status, modem status and receive buffer registers are presented as one-cycle strobes. A write of the transmit holding register is also a strobe, and so is the identification read itself. The block captures the identification byte on the read strobe and holds it on its output until the next read.

Top module: `uart_irq_ident`

## Requirements
- R1: The enable register stores write-data bits 3:0. Bit 0 enables receive-ready and timeout, bit 1 enables transmit-empty, bit 2 enables line error and bit 3 enables modem change. Bits 7:4 of the readback are always 0. A write updates `ier_rdata` on the same clock edge.
- R2: Priority runs from line error (code 0110) through receive level, then transmit-empty (0010), then modem change (0000). The receive level covers timeout (1100) and receive-ready (0100), and within it timeout wins. With nothing reported, the code is 0001. Bit 0 is low while an interrupt is pending.
- R3: A pending source whose enable bit is 0 appears neither in the identification byte nor on `irq`.
- R4: The identification byte has bits 5:4 at 0 and bits 7:6 both equal to `fifo_en`. When `fifo_en` is 0, bit 3 is 0, so timeout reads as 0100.
- R5: `irq` is registered. It is high exactly one cycle after any enabled flag is pending, and low one cycle after none is.
- R6: The line-error flag is set by `ls_evt` and cleared by `lsr_rd`. The modem-change flag is set by `ms_evt` and cleared by `msr_rd`. A set in the same cycle as a clear wins.
- R7: The receive-ready source follows the `rx_avail` level with no storage.
- R8: The timeout flag is set by `rx_tmo` and cleared only by `rbr_rd`. An identification read leaves it set.
- R9: The transmit-empty flag is set on a rising edge of `thre_empty`. It is cleared by `thr_wr`, or by an identification read whose captured code is 0010. A read that reports another code leaves it set.
- R10: The transmit-empty flag re-arms when enable bit 1 is written from 0 to 1 while `thre_empty` is high. Rewriting a bit that is already 1 does nothing.
- R11: `iir_rdata` is loaded on the edge where `iir_rd` is high and otherwise holds its value.
- R12: A synchronous active-high `rst` clears all flags and the enable register, drives `irq` low and sets `iir_rdata` to 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_we | input | 1 | Enable register write strobe |
| ier_wdata | input | DATA_W | Enable register write data |
| ier_rdata | output | DATA_W | Enable register readback |
| fifo_en | input | 1 | FIFO mode control bit |
| ls_evt | input | 1 | Line error event (overrun, parity, framing, break) |
| ms_evt | input | 1 | Modem input change event |
| rx_avail | input | 1 | Receive data ready or trigger level reached (level) |
| rx_tmo | input | 1 | Character timeout reached (event) |
| thre_empty | input | 1 | Transmit holding register empty (level) |
| lsr_rd | input | 1 | Line status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iir_rd | input | 1 | Identification register read strobe |
| iir_rdata | output | DATA_W | Captured identification byte |
| irq | output | 1 | Interrupt request |

## Verification
Each stimulus applied before clock edge k sets or clears a pending flag at edge k. The identification byte taken on a read strobe at edge k+1 reflects that change, and `irq` changes at edge k+1. All inputs change on falling edges and every output is sampled on a falling edge. A pulse is therefore followed by two falling edges before `irq` is compared, and by one read strobe plus one falling edge before `iir_rdata` is compared. One check deliberately samples after only a single edge to confirm that `irq` has not yet moved. Clear-on-access cases add one more edge for the flag to drop before the next observation.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int unsigned IER_W  = 4;
  localparam int unsigned CODE_W = 4;

  localparam int unsigned EN_RX = 0;
  localparam int unsigned EN_TX = 1;
  localparam int unsigned EN_LS = 2;
  localparam int unsigned EN_MS = 3;

  typedef enum logic [CODE_W-1:0] {
    IID_MS   = 4'b0000,
    IID_NONE = 4'b0001,
    IID_TX   = 4'b0010,
    IID_RX   = 4'b0100,
    IID_LS   = 4'b0110,
    IID_TMO  = 4'b1100
  } iid_e;

  typedef struct packed {
    logic ls;
    logic tmo;
    logic rx;
    logic tx;
    logic ms;
  } pend_t;

endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= set_i | (q_o & ~clr_i);
  end

endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
  input  logic clk,
  input  logic rst,
  input  logic thre_i,
  input  logic rearm_i,
  input  logic clr_i,
  output logic q_o
);

  logic thre_d;
  logic rise;

  assign rise = thre_i & ~thre_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      thre_d <= 1'b0;
      q_o    <= 1'b0;
    end else begin
      thre_d <= thre_i;
      q_o    <= rise | rearm_i | (q_o & ~clr_i);
    end
  end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  pend_t             pend_i,
  input  logic [IER_W-1:0]  en_i,
  input  logic              fifo_i,
  output logic [DATA_W-1:0] iir_o,
  output logic              any_o
);

  pend_t live;
  iid_e  code;
  logic [CODE_W-1:0] code_m;

  always_comb begin
    live     = pend_i;
    live.ls  = pend_i.ls  & en_i[EN_LS];
    live.tmo = pend_i.tmo & en_i[EN_RX];
    live.rx  = pend_i.rx  & en_i[EN_RX];
    live.tx  = pend_i.tx  & en_i[EN_TX];
    live.ms  = pend_i.ms  & en_i[EN_MS];
  end

  always_comb begin
    if      (live.ls)  code = IID_LS;
    else if (live.tmo) code = IID_TMO;
    else if (live.rx)  code = IID_RX;
    else if (live.tx)  code = IID_TX;
    else if (live.ms)  code = IID_MS;
    else               code = IID_NONE;
  end

  always_comb begin
    code_m    = code;
    code_m[3] = code[3] & fifo_i;
    iir_o     = '0;
    iir_o[CODE_W-1:0]  = code_m;
    iir_o[DATA_W-1 -: 2] = {2{fifo_i}};
  end

  assign any_o = |live;

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ier_we,
  input  logic [DATA_W-1:0] ier_wdata,
  output logic [DATA_W-1:0] ier_rdata,
  input  logic              fifo_en,
  input  logic              ls_evt,
  input  logic              ms_evt,
  input  logic              rx_avail,
  input  logic              rx_tmo,
  input  logic              thre_empty,
  input  logic              lsr_rd,
  input  logic              msr_rd,
  input  logic              rbr_rd,
  input  logic              thr_wr,
  input  logic              iir_rd,
  output logic [DATA_W-1:0] iir_rdata,
  output logic              irq
);

  localparam int unsigned NSTK = 3;
  localparam logic [DATA_W-1:0] IIR_RST = DATA_W'(IID_NONE);

  logic [IER_W-1:0] ier_q;
  logic [NSTK-1:0]  stk_set, stk_clr, stk_q;
  logic             tx_q, tx_clr, tx_rearm, any;
  logic [DATA_W-1:0] iir_live;
  pend_t            pend;
  logic             unused_wbits;

  assign unused_wbits = ^ier_wdata[DATA_W-1:IER_W];

  always_ff @(posedge clk) begin
    if (rst)         ier_q <= '0;
    else if (ier_we) ier_q <= ier_wdata[IER_W-1:0];
  end

  assign ier_rdata = DATA_W'(ier_q);

  assign stk_set = {rx_tmo, ms_evt, ls_evt};
  assign stk_clr = {rbr_rd, msr_rd, lsr_rd};

  for (genvar g = 0; g < NSTK; g++) begin : g_stk
    uart_irq_sticky u_stk (
      .clk   (clk),
      .rst   (rst),
      .set_i (stk_set[g]),
      .clr_i (stk_clr[g]),
      .q_o   (stk_q[g])
    );
  end

  assign tx_rearm = ier_we & ier_wdata[EN_TX] & ~ier_q[EN_TX] & thre_empty;
  assign tx_clr   = thr_wr | (iir_rd & (iir_live[CODE_W-1:0] == IID_TX));

  uart_irq_thre u_thre (
    .clk     (clk),
    .rst     (rst),
    .thre_i  (thre_empty),
    .rearm_i (tx_rearm),
    .clr_i   (tx_clr),
    .q_o     (tx_q)
  );

  always_comb begin
    pend.ls  = stk_q[0];
    pend.ms  = stk_q[1];
    pend.tmo = stk_q[2];
    pend.rx  = rx_avail;
    pend.tx  = tx_q;
  end

  uart_irq_prio #(.DATA_W(DATA_W)) u_prio (
    .pend_i (pend),
    .en_i   (ier_q),
    .fifo_i (fifo_en),
    .iir_o  (iir_live),
    .any_o  (any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      iir_rdata <= IIR_RST;
    end else begin
      irq <= any;
      if (iir_rd) iir_rdata <= iir_live;
    end
  end

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ier_we,
  input logic [DATA_W-1:0] ier_rdata,
  input logic              fifo_en,
  input logic              thre_empty,
  input logic              thr_wr,
  input logic              lsr_rd,
  input logic              ls_evt,
  input logic              iir_rd,
  input logic [DATA_W-1:0] iir_rdata,
  input logic              irq
);

  assert_ier_upper_R1: assert property (@(posedge clk) disable iff (rst)
    ier_rdata[DATA_W-1:4] == '0);

  assert_fixed_bits_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(iir_rd) |->
      iir_rdata[5:4] == 2'b00 && iir_rdata[DATA_W-1 -: 2] == {2{$past(fifo_en)}});

  assert_bit3_nofifo_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(iir_rd) && !$past(fifo_en) |-> !iir_rdata[3]);

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(iir_rd) |-> $stable(iir_rdata));

  assert_idle_irq_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(ier_rdata[3:0]) == 4'h0 |-> !irq);

  assert_lsr_clear_R6: assert property (@(posedge clk) disable iff (rst)
    iir_rd && $past(lsr_rd) && !$past(ls_evt) && !$past(rst) |=> iir_rdata[3:0] != 4'b0110);

  assert_thr_clear_R9: assert property (@(posedge clk) disable iff (rst)
    iir_rd && !$past(rst) && !$past(rst, 2) && $past(thr_wr) && !$past(ier_we)
      && $past(thre_empty) && $past(thre_empty, 2) |=> iir_rdata[3:0] != 4'b0010);

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ier_we(ier_we), .ier_rdata(ier_rdata), .fifo_en(fifo_en),
  .thre_empty(thre_empty), .thr_wr(thr_wr), .lsr_rd(lsr_rd), .ls_evt(ls_evt),
  .iir_rd(iir_rd), .iir_rdata(iir_rdata), .irq(irq)
);

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ier_we = 0, fifo_en = 0, ls_evt = 0, ms_evt = 0, rx_avail = 0, rx_tmo = 0;
  logic thre_empty = 0, lsr_rd = 0, msr_rd = 0, rbr_rd = 0, thr_wr = 0, iir_rd = 0;
  logic [7:0] ier_wdata = 0;
  logic [7:0] ier_rdata, iir_rdata;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_irq_ident dut (
    .clk(clk), .rst(rst), .ier_we(ier_we), .ier_wdata(ier_wdata), .ier_rdata(ier_rdata),
    .fifo_en(fifo_en), .ls_evt(ls_evt), .ms_evt(ms_evt), .rx_avail(rx_avail),
    .rx_tmo(rx_tmo), .thre_empty(thre_empty), .lsr_rd(lsr_rd), .msr_rd(msr_rd),
    .rbr_rd(rbr_rd), .thr_wr(thr_wr), .iir_rd(iir_rd), .iir_rdata(iir_rdata), .irq(irq)
  );

  // {ier[3:0], fifo, ls, avail, tmo, thre, ms, exp_iir[7:0], exp_irq}
  localparam int NV = 12;
  localparam logic [18:0] VEC [NV] = '{
    {4'hF, 6'b111111, 8'hC6, 1'b1},
    {4'hF, 6'b101111, 8'hCC, 1'b1},
    {4'hF, 6'b101011, 8'hC4, 1'b1},
    {4'hF, 6'b100011, 8'hC2, 1'b1},
    {4'hF, 6'b100001, 8'hC0, 1'b1},
    {4'h0, 6'b111111, 8'hC1, 1'b0},
    {4'hE, 6'b001110, 8'h02, 1'b1},
    {4'h1, 6'b000100, 8'h04, 1'b1},
    {4'h8, 6'b011011, 8'h00, 1'b1},
    {4'h4, 6'b000000, 8'h01, 1'b0},
    {4'h2, 6'b111001, 8'hC1, 1'b0},
    {4'h5, 6'b111000, 8'hC6, 1'b1}
  };

  task automatic tick(); @(negedge clk); endtask

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rx_avail = 0; thre_empty = 0; fifo_en = 0;
    rst = 1; tick(); tick(); rst = 0;
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_we = 1; ier_wdata = v; tick(); ier_we = 0;
  endtask

  task automatic rd_iir(output logic [7:0] v);
    iir_rd = 1; tick(); iir_rd = 0; v = iir_rdata;
  endtask

  initial begin
    logic [7:0] r;
    tick();
    do_reset();
    // R12 reset state
    check({7'd0, irq}, 8'h00, "R12 irq after reset");
    check(ier_rdata, 8'h00, "R12 ier after reset");
    check(iir_rdata, 8'h01, "R12 iir after reset");

    // R1 upper enable bits read zero
    wr_ier(8'hFF);
    check(ier_rdata, 8'h0F, "R1 ier readback");

    // Vector table: R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v = VEC[i];
      do_reset();
      fifo_en = v[14];
      wr_ier({4'h0, v[18:15]});
      ls_evt = v[13]; rx_avail = v[12]; rx_tmo = v[11]; thre_empty = v[10]; ms_evt = v[9];
      tick();
      ls_evt = 0; rx_tmo = 0; ms_evt = 0;
      tick();
      check({7'd0, irq}, {7'd0, v[0]}, $sformatf("R3 R5 vector %0d irq", i));
      rd_iir(r);
      check(r, v[8:1], $sformatf("R2 R4 vector %0d iir", i));
    end

    // R5 latency and R6 modem clear
    do_reset(); wr_ier(8'h08);
    ms_evt = 1; tick(); ms_evt = 0;
    check({7'd0, irq}, 8'h00, "R5 irq not yet up after one edge");
    tick();
    check({7'd0, irq}, 8'h01, "R5 irq up after two edges");
    msr_rd = 1; tick(); msr_rd = 0; tick();
    check({7'd0, irq}, 8'h00, "R6 modem cleared by msr read");

    // R6 line error: clear, and set wins over clear
    wr_ier(8'h04);
    ls_evt = 1; tick(); ls_evt = 0; tick();
    check({7'd0, irq}, 8'h01, "R6 line error pending");
    lsr_rd = 1; tick(); lsr_rd = 0; tick();
    check({7'd0, irq}, 8'h00, "R6 line error cleared by lsr read");
    ls_evt = 1; lsr_rd = 1; tick(); ls_evt = 0; lsr_rd = 0; tick();
    check({7'd0, irq}, 8'h01, "R6 set wins over clear");

    // R7 receive level follows input
    do_reset(); wr_ier(8'h01);
    rx_avail = 1; tick(); tick();
    check({7'd0, irq}, 8'h01, "R7 rx level high");
    rx_avail = 0; tick(); tick();
    check({7'd0, irq}, 8'h00, "R7 rx level low");

    // R8 timeout sticky until buffer read
    fifo_en = 1;
    rx_tmo = 1; tick(); rx_tmo = 0; tick();
    rd_iir(r); check(r, 8'hCC, "R8 timeout code");
    rd_iir(r); check(r, 8'hCC, "R8 timeout survives iir read");
    rbr_rd = 1; tick(); rbr_rd = 0; tick();
    check({7'd0, irq}, 8'h00, "R8 timeout cleared by buffer read");

    // R9 transmit-empty clears
    do_reset(); wr_ier(8'h02);
    thre_empty = 1; tick(); tick();
    check({7'd0, irq}, 8'h01, "R9 thre rise sets");
    rd_iir(r); check(r, 8'h02, "R9 thre code");
    tick();
    check({7'd0, irq}, 8'h00, "R9 cleared by iir read");
    thre_empty = 0; tick(); thre_empty = 1; tick(); tick();
    check({7'd0, irq}, 8'h01, "R9 second rise sets");
    thr_wr = 1; tick(); thr_wr = 0; tick();
    check({7'd0, irq}, 8'h00, "R9 cleared by thr write");

    // R9 read reporting another source leaves thre pending
    do_reset(); wr_ier(8'h06);
    thre_empty = 1; ls_evt = 1; tick(); ls_evt = 0; tick();
    rd_iir(r); check(r, 8'h06, "R9 line error reported first");
    lsr_rd = 1; tick(); lsr_rd = 0;
    rd_iir(r); check(r, 8'h02, "R9 thre kept after other-code read");

    // R10 re-arm on enable
    do_reset();
    thre_empty = 1; tick();
    thr_wr = 1; tick(); thr_wr = 0;
    wr_ier(8'h02); tick();
    check({7'd0, irq}, 8'h01, "R10 re-armed by enable write");
    rd_iir(r); check(r, 8'h02, "R10 re-armed code");
    wr_ier(8'h02); tick();
    check({7'd0, irq}, 8'h00, "R10 rewrite of set bit no re-arm");

    // R11 captured byte holds
    do_reset(); fifo_en = 1; wr_ier(8'h0F);
    ls_evt = 1; tick(); ls_evt = 0; tick();
    rd_iir(r);
    ms_evt = 1; lsr_rd = 1; tick(); ms_evt = 0; lsr_rd = 0; tick(); tick();
    check(iir_rdata, 8'hC6, "R11 byte held between reads");
    rd_iir(r); check(r, 8'hC0, "R11 next read updates");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule